// File: doc/BRIEF.md
# CAN receive mailbox filter

This block sits behind a CAN receiver that has already decoded and checked each frame. A frame arrives in a single cycle as an identifier, a length code and eight data bytes, marked by `fr_valid`. The block picks the receive object that the frame belongs to and stores the frame there. It then raises a per-object interrupt level toward a host, which drains the objects through a simple read port. Frames are selected by message identifier, never by a node address, so one node can own several identifiers spread over several objects.

Each object is configured through static inputs with a kind, an identifier filter and mask, an optional key filter on the first two data bytes, and an interrupt threshold. Single-slot objects keep only the latest matching frame. Queued objects buffer matching frames in a small FIFO and only interrupt once enough frames have gathered. A catch-all object collects every frame that no dedicated object claims, so traffic that needs no dedicated handling is still seen.

All objects share one entry memory written so that block RAM can be inferred. The per-object pointers and counters live in registers.

Top module: `can_rx_mailbox`

## Requirements
- R1: After a synchronous reset, every object is empty, and `irq`, `ovf` and `rd_valid` are all zero.
- R2: A dedicated object (single-slot or queued) accepts a frame when `((fr_id ^ filter) & mask) == 0` and its key test passes. When several dedicated objects accept a frame, the lowest index receives it.
- R3: With the key enable set, an object also requires `((fr_data[15:0] ^ key) & key_mask) == 0` (first data byte in bits 7:0, second byte in bits 15:8) and a length code of at least 2; otherwise it does not accept.
- R4: A frame no dedicated object accepts goes to the lowest-index catch-all object, or is discarded if there is none. A catch-all object is a FIFO whose interrupt is high while it holds any frame.
- R5: A single-slot object stores the identifier, length and data of the accepted frame, and its interrupt is high until the host reads it. A newer matching frame that arrives before the read replaces the stored frame.
- R6: A queued object returns frames in arrival order. Its interrupt is high while its count is at least its threshold (a threshold of 0 acts as 1) and low when it is empty.
- R7: A frame routed to a full queued or catch-all object is dropped and sets that object's sticky `ovf` bit. A pulse on `ovf_clr` clears the bit, but a drop in the same cycle keeps it set.
- R8: A `rd_req` pulse with `rd_obj` gives `rd_valid` one cycle later. If the object held a frame, `rd_found` is 1, `rd_id`, `rd_len` and `rd_data` carry its oldest frame, and that frame is removed. If the object was empty, `rd_found` is 0 and nothing changes.
- R9: A received length code above 8 is stored and returned as 8.
- R10: Kind codes are 0 = off, 1 = single-slot, 2 = queued, 3 = catch-all. An object set to off never accepts a frame, and its interrupt stays low.
- R11: A read and a frame in the same cycle see the object as it was before that cycle: the read returns the older content, and a frame arriving at a full FIFO is dropped even if the same cycle's read frees a place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fr_valid | input | 1 | A decoded frame is present this cycle |
| fr_id | input | ID_W | Frame identifier |
| fr_len | input | 4 | Frame length code |
| fr_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| cfg_kind | input | 2*NUM_OBJ | Per-object kind code |
| cfg_id | input | ID_W*NUM_OBJ | Per-object identifier filter |
| cfg_id_mask | input | ID_W*NUM_OBJ | Per-object identifier mask (1 = compare) |
| cfg_key_en | input | NUM_OBJ | Per-object enable of the two-byte key test |
| cfg_key | input | 16*NUM_OBJ | Per-object key value |
| cfg_key_mask | input | 16*NUM_OBJ | Per-object key mask (1 = compare) |
| cfg_thresh | input | CNT_W*NUM_OBJ | Per-object interrupt threshold for queued objects |
| ovf_clr | input | NUM_OBJ | Clear pulses for the overflow bits |
| rd_req | input | 1 | Read-and-remove request |
| rd_obj | input | OBJ_W | Object selected for the read |
| rd_valid | output | 1 | Read answer present |
| rd_found | output | 1 | The read object held a frame |
| rd_id | output | ID_W | Identifier of the returned frame |
| rd_len | output | 4 | Clamped length of the returned frame |
| rd_data | output | 64 | Data of the returned frame |
| irq | output | NUM_OBJ | Per-object interrupt levels |
| ovf | output | NUM_OBJ | Per-object sticky overflow bits |

## Verification
Directed frames test the priority and key rules separately. An identifier claimed by two dedicated objects shows whether the lowest index wins. A key-qualified identifier sent with the right key, with too short a length and with a wrong key shows whether the key test and the catch-all fallback are applied. Queued objects are filled one frame at a time, which locates the exact frame at which the threshold interrupt rises. They are then filled past capacity, with and without a read in the same cycle, which separates a correct drop-and-flag from a lost or overwritten entry. A long constrained-random run follows, mixing identifiers that hit each object with random ones, random lengths above 8, random reads and random clears. Every read and every interrupt and overflow bit is compared against a reference model of the objects kept in the bench.

// File: rtl/can_mbx_pkg.sv
package can_mbx_pkg;
  typedef enum logic [1:0] {
    OBJ_OFF    = 2'd0,
    OBJ_SINGLE = 2'd1,
    OBJ_QUEUE  = 2'd2,
    OBJ_CATCH  = 2'd3
  } obj_kind_e;

  function automatic logic [3:0] clamp_len(input logic [3:0] len);
    return (len > 4'd8) ? 4'd8 : len;
  endfunction
endpackage

// File: rtl/can_mbx_match.sv
module can_mbx_match
  import can_mbx_pkg::*;
#(
  parameter int NUM_OBJ = 4,
  parameter int ID_W    = 11,
  parameter int OBJ_W   = 2
) (
  input  logic [ID_W-1:0]         fr_id,
  input  logic [3:0]              fr_len,
  input  logic [15:0]             fr_key,
  input  logic [2*NUM_OBJ-1:0]    cfg_kind,
  input  logic [ID_W*NUM_OBJ-1:0] cfg_id,
  input  logic [ID_W*NUM_OBJ-1:0] cfg_id_mask,
  input  logic [NUM_OBJ-1:0]      cfg_key_en,
  input  logic [16*NUM_OBJ-1:0]   cfg_key,
  input  logic [16*NUM_OBJ-1:0]   cfg_key_mask,
  output logic                    hit,
  output logic [OBJ_W-1:0]        hit_obj
);
  logic             ded_found, catch_found;
  logic [OBJ_W-1:0] ded_idx, catch_idx;

  always_comb begin
    ded_found   = 1'b0;
    catch_found = 1'b0;
    ded_idx     = '0;
    catch_idx   = '0;
    for (int i = 0; i < NUM_OBJ; i++) begin
      obj_kind_e kind;
      logic      id_ok, key_ok;
      kind   = obj_kind_e'(cfg_kind[i*2 +: 2]);
      id_ok  = ((fr_id ^ cfg_id[i*ID_W +: ID_W]) & cfg_id_mask[i*ID_W +: ID_W]) == '0;
      key_ok = !cfg_key_en[i] ||
               ((fr_len >= 4'd2) &&
                (((fr_key ^ cfg_key[i*16 +: 16]) & cfg_key_mask[i*16 +: 16]) == 16'h0));
      if ((kind == OBJ_SINGLE || kind == OBJ_QUEUE) && id_ok && key_ok && !ded_found) begin
        ded_found = 1'b1;
        ded_idx   = OBJ_W'(i);
      end
      if (kind == OBJ_CATCH && !catch_found) begin
        catch_found = 1'b1;
        catch_idx   = OBJ_W'(i);
      end
    end
    hit     = ded_found || catch_found;
    hit_obj = ded_found ? ded_idx : catch_idx;
  end
endmodule

// File: rtl/can_mbx_ctrl.sv
module can_mbx_ctrl
  import can_mbx_pkg::*;
#(
  parameter int NUM_OBJ    = 4,
  parameter int FIFO_DEPTH = 4,
  parameter int OBJ_W      = 2,
  parameter int PTR_W      = 2,
  parameter int CNT_W      = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push,
  input  logic [OBJ_W-1:0]         push_obj,
  input  logic                     pop_req,
  input  logic [OBJ_W-1:0]         pop_obj,
  input  logic [2*NUM_OBJ-1:0]     cfg_kind,
  input  logic [CNT_W*NUM_OBJ-1:0] cfg_thresh,
  input  logic [NUM_OBJ-1:0]       ovf_clr,
  output logic                     wr_en,
  output logic [OBJ_W+PTR_W-1:0]   wr_addr,
  output logic [OBJ_W+PTR_W-1:0]   rd_addr,
  output logic                     rd_hit,
  output logic [NUM_OBJ-1:0]       irq,
  output logic [NUM_OBJ-1:0]       ovf
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(FIFO_DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

  obj_kind_e        kind_a [NUM_OBJ];
  logic [CNT_W-1:0] cnt_q  [NUM_OBJ];
  logic [CNT_W-1:0] cnt_d  [NUM_OBJ];
  logic [PTR_W-1:0] wp_q   [NUM_OBJ];
  logic [PTR_W-1:0] wp_d   [NUM_OBJ];
  logic [PTR_W-1:0] rp_q   [NUM_OBJ];
  logic [PTR_W-1:0] rp_d   [NUM_OBJ];
  logic [NUM_OBJ-1:0] acc, drop, pop, irq_d, ovf_d;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    for (int o = 0; o < NUM_OBJ; o++) begin
      logic             single, is_push, full;
      logic [CNT_W-1:0] thr;
      kind_a[o] = obj_kind_e'(cfg_kind[o*2 +: 2]);
      single    = (kind_a[o] == OBJ_SINGLE);
      is_push   = push && (push_obj == OBJ_W'(o));
      full      = (cnt_q[o] == FULL_CNT);
      pop[o]    = pop_req && (pop_obj == OBJ_W'(o)) && (cnt_q[o] != '0);
      acc[o]    = is_push && (single || !full);
      drop[o]   = is_push && !single && full;
      wp_d[o]   = wp_q[o];
      rp_d[o]   = rp_q[o];
      if (single) begin
        cnt_d[o] = acc[o] ? CNT_W'(1) : (pop[o] ? '0 : cnt_q[o]);
      end else begin
        cnt_d[o] = cnt_q[o] + CNT_W'(acc[o]) - CNT_W'(pop[o]);
        if (acc[o]) wp_d[o] = ptr_inc(wp_q[o]);
        if (pop[o]) rp_d[o] = ptr_inc(rp_q[o]);
      end
      thr = cfg_thresh[o*CNT_W +: CNT_W];
      if (thr == '0) thr = CNT_W'(1);
      case (kind_a[o])
        OBJ_SINGLE, OBJ_CATCH: irq_d[o] = (cnt_d[o] != '0);
        OBJ_QUEUE:             irq_d[o] = (cnt_d[o] >= thr);
        default:               irq_d[o] = 1'b0;
      endcase
      ovf_d[o] = (ovf[o] && !ovf_clr[o]) || drop[o];
    end
  end

  assign wr_en   = |acc;
  assign wr_addr = {push_obj, (kind_a[push_obj] == OBJ_SINGLE) ? {PTR_W{1'b0}} : wp_q[push_obj]};
  assign rd_addr = {pop_obj,  (kind_a[pop_obj]  == OBJ_SINGLE) ? {PTR_W{1'b0}} : rp_q[pop_obj]};
  assign rd_hit  = (cnt_q[pop_obj] != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= '0;
      ovf <= '0;
      for (int o = 0; o < NUM_OBJ; o++) begin
        cnt_q[o] <= '0;
        wp_q[o]  <= '0;
        rp_q[o]  <= '0;
      end
    end else begin
      irq <= irq_d;
      ovf <= ovf_d;
      for (int o = 0; o < NUM_OBJ; o++) begin
        cnt_q[o] <= cnt_d[o];
        wp_q[o]  <= wp_d[o];
        rp_q[o]  <= rp_d[o];
      end
    end
  end

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_chk
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      cnt_q[g] <= FULL_CNT); // R6
    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (rst)
      (cnt_q[g] == '0) |-> !irq[g]); // R6
    AST_SINGLE_ONE: assert property (@(posedge clk) disable iff (rst)
      (acc[g] && kind_a[g] == OBJ_SINGLE) |=> (cnt_q[g] == CNT_W'(1))); // R5
    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (rst)
      (ovf[g] && !ovf_clr[g]) |=> ovf[g]); // R7
    AST_DROP_FLAG: assert property (@(posedge clk) disable iff (rst)
      drop[g] |=> ovf[g]); // R7
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
      (kind_a[g] == OBJ_OFF) |-> !acc[g]); // R10
  end
endmodule

// File: rtl/can_mbx_store.sv
module can_mbx_store #(
  parameter int ADDR_W = 4,
  parameter int ENT_W  = 79
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [ENT_W-1:0]  wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [ENT_W-1:0]  rdata
);
  logic [ENT_W-1:0] mem [2**ADDR_W];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/can_rx_mailbox.sv
module can_rx_mailbox
  import can_mbx_pkg::*;
#(
  parameter int NUM_OBJ    = 4,
  parameter int FIFO_DEPTH = 4,
  parameter int ID_W       = 11,
  parameter int OBJ_W      = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fr_valid,
  input  logic [ID_W-1:0]          fr_id,
  input  logic [3:0]               fr_len,
  input  logic [63:0]              fr_data,
  input  logic [2*NUM_OBJ-1:0]     cfg_kind,
  input  logic [ID_W*NUM_OBJ-1:0]  cfg_id,
  input  logic [ID_W*NUM_OBJ-1:0]  cfg_id_mask,
  input  logic [NUM_OBJ-1:0]       cfg_key_en,
  input  logic [16*NUM_OBJ-1:0]    cfg_key,
  input  logic [16*NUM_OBJ-1:0]    cfg_key_mask,
  input  logic [CNT_W*NUM_OBJ-1:0] cfg_thresh,
  input  logic [NUM_OBJ-1:0]       ovf_clr,
  input  logic                     rd_req,
  input  logic [OBJ_W-1:0]         rd_obj,
  output logic                     rd_valid,
  output logic                     rd_found,
  output logic [ID_W-1:0]          rd_id,
  output logic [3:0]               rd_len,
  output logic [63:0]              rd_data,
  output logic [NUM_OBJ-1:0]       irq,
  output logic [NUM_OBJ-1:0]       ovf
);
  localparam int PTR_W  = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int ADDR_W = OBJ_W + PTR_W;
  localparam int ENT_W  = ID_W + 4 + 64;

  logic              hit, wr_en, rd_hit;
  logic [OBJ_W-1:0]  hit_obj;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [ENT_W-1:0]  ent_rd;

  can_mbx_match #(.NUM_OBJ(NUM_OBJ), .ID_W(ID_W), .OBJ_W(OBJ_W)) i_match (
    .fr_id(fr_id), .fr_len(fr_len), .fr_key(fr_data[15:0]),
    .cfg_kind(cfg_kind), .cfg_id(cfg_id), .cfg_id_mask(cfg_id_mask),
    .cfg_key_en(cfg_key_en), .cfg_key(cfg_key), .cfg_key_mask(cfg_key_mask),
    .hit(hit), .hit_obj(hit_obj)
  );

  can_mbx_ctrl #(.NUM_OBJ(NUM_OBJ), .FIFO_DEPTH(FIFO_DEPTH), .OBJ_W(OBJ_W),
                 .PTR_W(PTR_W), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rst(rst), .push(fr_valid && hit), .push_obj(hit_obj),
    .pop_req(rd_req), .pop_obj(rd_obj), .cfg_kind(cfg_kind), .cfg_thresh(cfg_thresh),
    .ovf_clr(ovf_clr), .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .rd_hit(rd_hit), .irq(irq), .ovf(ovf)
  );

  can_mbx_store #(.ADDR_W(ADDR_W), .ENT_W(ENT_W)) i_store (
    .clk(clk), .we(wr_en), .waddr(wr_addr),
    .wdata({fr_id, clamp_len(fr_len), fr_data}),
    .re(rd_req && rd_hit), .raddr(rd_addr), .rdata(ent_rd)
  );

  assign {rd_id, rd_len, rd_data} = ent_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_found <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      rd_found <= rd_req && rd_hit;
    end
  end

  AST_RD_ANSWER: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid); // R8
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_valid && !rd_found); // R8
  AST_LEN_CLAMP: assert property (@(posedge clk) disable iff (rst)
    rd_found |-> (rd_len <= 4'd8)); // R9
endmodule

// File: tb/test_can_rx_mailbox.sv
module test_can_rx_mailbox;
  localparam int CLK_PERIOD = 10;
  localparam int NO  = 4;
  localparam int DEP = 4;
  localparam int IDW = 11;
  localparam int CW  = 3;
  localparam int OW  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fr_valid = 1'b0;
  logic [IDW-1:0] fr_id = '0;
  logic [3:0] fr_len = '0;
  logic [63:0] fr_data = '0;
  logic [2*NO-1:0] cfg_kind;
  logic [IDW*NO-1:0] cfg_id, cfg_id_mask;
  logic [NO-1:0] cfg_key_en;
  logic [16*NO-1:0] cfg_key, cfg_key_mask;
  logic [CW*NO-1:0] cfg_thresh;
  logic [NO-1:0] ovf_clr = '0;
  logic rd_req = 1'b0;
  logic [OW-1:0] rd_obj = '0;
  logic rd_valid, rd_found;
  logic [IDW-1:0] rd_id;
  logic [3:0] rd_len;
  logic [63:0] rd_data;
  logic [NO-1:0] irq, ovf;

  logic [1:0]     b_kind  [NO];
  logic [IDW-1:0] b_id    [NO];
  logic [IDW-1:0] b_idm   [NO];
  logic           b_key_en[NO];
  logic [15:0]    b_key   [NO];
  logic [15:0]    b_keym  [NO];
  logic [CW-1:0]  b_thr   [NO];

  always_comb begin
    for (int i = 0; i < NO; i++) begin
      cfg_kind[i*2 +: 2]       = b_kind[i];
      cfg_id[i*IDW +: IDW]     = b_id[i];
      cfg_id_mask[i*IDW +: IDW] = b_idm[i];
      cfg_key_en[i]            = b_key_en[i];
      cfg_key[i*16 +: 16]      = b_key[i];
      cfg_key_mask[i*16 +: 16] = b_keym[i];
      cfg_thresh[i*CW +: CW]   = b_thr[i];
    end
  end

  can_rx_mailbox #(.NUM_OBJ(NO), .FIFO_DEPTH(DEP), .ID_W(IDW)) i_can_rx_mailbox (
    .clk(clk), .rst(rst), .fr_valid(fr_valid), .fr_id(fr_id), .fr_len(fr_len),
    .fr_data(fr_data), .cfg_kind(cfg_kind), .cfg_id(cfg_id), .cfg_id_mask(cfg_id_mask),
    .cfg_key_en(cfg_key_en), .cfg_key(cfg_key), .cfg_key_mask(cfg_key_mask),
    .cfg_thresh(cfg_thresh), .ovf_clr(ovf_clr), .rd_req(rd_req), .rd_obj(rd_obj),
    .rd_valid(rd_valid), .rd_found(rd_found), .rd_id(rd_id), .rd_len(rd_len),
    .rd_data(rd_data), .irq(irq), .ovf(ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model of the objects
  logic [IDW-1:0] m_id   [NO][DEP];
  logic [3:0]     m_len  [NO][DEP];
  logic [63:0]    m_data [NO][DEP];
  int             m_head [NO];
  int             m_cnt  [NO];
  bit             m_ovf  [NO];

  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int winner(input logic [IDW-1:0] id, input logic [3:0] len, input logic [63:0] d);
    for (int i = 0; i < NO; i++) begin
      if ((b_kind[i] == 2'd1 || b_kind[i] == 2'd2) && (((id ^ b_id[i]) & b_idm[i]) == '0) &&
          (!b_key_en[i] || (len >= 4'd2 && (((d[15:0] ^ b_key[i]) & b_keym[i]) == 16'h0))))
        return i;
    end
    for (int i = 0; i < NO; i++)
      if (b_kind[i] == 2'd3) return i;
    return -1;
  endfunction

  function automatic bit exp_irq(input int o);
    int t;
    t = (b_thr[o] == 0) ? 1 : int'(b_thr[o]);
    case (b_kind[o])
      2'd1, 2'd3: return m_cnt[o] != 0;
      2'd2:       return m_cnt[o] >= t;
      default:    return 1'b0;
    endcase
  endfunction

  task automatic step(input bit fv, input logic [IDW-1:0] id, input logic [3:0] len,
                      input logic [63:0] d, input bit rq, input int ro,
                      input logic [NO-1:0] clr, input string tag);
    int w;
    bit wfull, dropped;
    fr_valid = fv; fr_id = id; fr_len = len; fr_data = d;
    rd_req = rq; rd_obj = OW'(ro); ovf_clr = clr;
    @(posedge clk);
    #1;
    fr_valid = 1'b0; rd_req = 1'b0; ovf_clr = '0;
    w = fv ? winner(id, len, d) : -1;
    wfull = (w >= 0) && (m_cnt[w] == DEP);
    dropped = 1'b0;
    chk(rd_valid == rq, {tag, " rd_valid"}, 64'(rd_valid), 64'(rq));
    if (rq) begin
      bit ef;
      ef = m_cnt[ro] > 0;
      chk(rd_found == ef, {tag, " rd_found"}, 64'(rd_found), 64'(ef));
      if (ef) begin
        int h;
        h = m_head[ro];
        chk(rd_id == m_id[ro][h], {tag, " rd_id"}, 64'(rd_id), 64'(m_id[ro][h]));
        chk(rd_len == m_len[ro][h], {tag, " rd_len"}, 64'(rd_len), 64'(m_len[ro][h]));
        chk(rd_data == m_data[ro][h], {tag, " rd_data"}, rd_data, m_data[ro][h]);
        if (b_kind[ro] == 2'd1) m_cnt[ro] = 0;
        else begin m_head[ro] = (h + 1) % DEP; m_cnt[ro]--; end
      end
    end else begin
      chk(rd_found == 1'b0, {tag, " rd_found idle"}, 64'(rd_found), 64'd0);
    end
    if (w >= 0) begin
      if (b_kind[w] == 2'd1) begin
        m_id[w][0] = id; m_len[w][0] = (len > 8) ? 4'd8 : len; m_data[w][0] = d;
        m_head[w] = 0; m_cnt[w] = 1;
      end else if (wfull) begin
        dropped = 1'b1;
      end else begin
        int s;
        s = (m_head[w] + m_cnt[w]) % DEP;
        m_id[w][s] = id; m_len[w][s] = (len > 8) ? 4'd8 : len; m_data[w][s] = d;
        m_cnt[w]++;
      end
    end
    for (int o = 0; o < NO; o++) begin
      m_ovf[o] = (m_ovf[o] && !clr[o]) || (dropped && o == w);
      chk(irq[o] == exp_irq(o), {tag, " irq"}, 64'(irq[o]), 64'(exp_irq(o)));
      chk(ovf[o] == m_ovf[o], {tag, " ovf"}, 64'(ovf[o]), 64'(m_ovf[o]));
    end
  endtask

  task automatic rd(input int o, input string tag);
    step(1'b0, '0, '0, '0, 1'b1, o, '0, tag);
  endtask

  task automatic fr(input logic [IDW-1:0] id, input logic [3:0] len, input logic [63:0] d, input string tag);
    step(1'b1, id, len, d, 1'b0, 0, '0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    b_kind[0] = 2'd1; b_id[0] = 11'h150; b_idm[0] = 11'h7FF; b_key_en[0] = 0; b_key[0] = 0;      b_keym[0] = 0;       b_thr[0] = 0;
    b_kind[1] = 2'd2; b_id[1] = 11'h3F0; b_idm[1] = 11'h7F0; b_key_en[1] = 0; b_key[1] = 0;      b_keym[1] = 0;       b_thr[1] = 3'd4;
    b_kind[2] = 2'd1; b_id[2] = 11'h100; b_idm[2] = 11'h700; b_key_en[2] = 1; b_key[2] = 16'hBEEF; b_keym[2] = 16'hFFFF; b_thr[2] = 0;
    b_kind[3] = 2'd3; b_id[3] = 11'h000; b_idm[3] = 11'h000; b_key_en[3] = 0; b_key[3] = 0;      b_keym[3] = 0;       b_thr[3] = 0;
    for (int o = 0; o < NO; o++) begin m_head[o] = 0; m_cnt[o] = 0; m_ovf[o] = 0; end

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk(irq == '0, "R1 reset irq", 64'(irq), 64'd0);
    chk(ovf == '0, "R1 reset ovf", 64'(ovf), 64'd0);
    chk(rd_valid == 1'b0, "R1 reset rd_valid", 64'(rd_valid), 64'd0);
    rd(0, "R1 empty after reset");

    // length clamp and single-slot storage
    fr(11'h150, 4'd12, 64'h0102030405060708, "R9 R5 long frame");
    rd(0, "R9 R5 read clamped");
    rd(0, "R8 read empty");
    // overwrite
    fr(11'h150, 4'd3, 64'hAAAA, "R5 first");
    fr(11'h150, 4'd4, 64'hBBBB, "R5 second");
    rd(0, "R5 overwrite read");
    // priority between two dedicated objects
    fr(11'h150, 4'd8, 64'h1122_3344_5566_BEEF, "R2 overlap");
    rd(2, "R2 loser empty");
    rd(0, "R2 winner read");
    // key test
    fr(11'h1AB, 4'd2, 64'hBEEF, "R3 key match");
    rd(2, "R3 key read");
    fr(11'h1AB, 4'd1, 64'hBEEF, "R3 R4 short key");
    rd(2, "R3 short not taken");
    rd(3, "R3 R4 short to catch-all");
    fr(11'h1AB, 4'd8, 64'h1234, "R3 R4 wrong key");
    rd(3, "R3 R4 wrong key to catch-all");
    // threshold
    for (int k = 1; k <= 4; k++) fr(IDW'(11'h3F0 + k), 4'(k), 64'(k * 17), "R6 fill");
    for (int k = 0; k < 4; k++) rd(1, "R6 order");
    // overflow and clear
    for (int k = 0; k < 5; k++) fr(11'h3F9, 4'd8, 64'(k), "R7 overfill");
    step(1'b0, '0, '0, '0, 1'b0, 0, 4'b0010, "R7 clear");
    step(1'b1, 11'h3F7, 4'd5, 64'hDEAD, 1'b1, 1, 4'b0010, "R11 R7 drop with read and clear");
    for (int k = 0; k < 4; k++) rd(1, "R11 drain");
    step(1'b0, '0, '0, '0, 1'b0, 0, 4'b0010, "R7 clear again");
    // catch-all
    fr(11'h7AA, 4'd6, 64'h5555, "R4 unclaimed");
    rd(3, "R4 catch-all read");

    // constrained random
    for (int n = 0; n < 2000; n++) begin
      logic [IDW-1:0] id;
      logic [63:0] d;
      int sel;
      sel = $urandom % 4;
      case (sel)
        0: id = 11'h150;
        1: id = {3'b001, 8'($urandom)};
        2: id = {7'h3F, 4'($urandom)};
        default: id = 11'($urandom);
      endcase
      d = {$urandom, $urandom};
      if ($urandom % 2 == 0) d[15:0] = 16'hBEEF;
      step(($urandom % 3) != 0, id, 4'($urandom), d, ($urandom % 5) < 2, int'($urandom % NO),
           (($urandom % 20) == 0) ? 4'($urandom) : 4'd0, "R2 R3 R4 R5 R6 R7 R8 R9 R11 random");
    end

    // drain, then switch an object off
    for (int o = 0; o < NO; o++) repeat (5) rd(o, "R8 drain");
    b_kind[2] = 2'd0;
    #1;
    fr(11'h1AB, 4'd2, 64'hBEEF, "R10 off object");
    rd(2, "R10 off stays empty");
    rd(3, "R10 routed to catch-all");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule